// File: doc/BRIEF.md
# Masked Condition-Field Lookup Logic Unit

This unit executes two condition-register field instructions against a 32-bit condition register that it holds internally as eight 4-bit fields. The ternary form treats the destination field and two source fields as a 3-bit index per bit position into an 8-entry truth table carried in the instruction word. The binary form uses the destination field and one source field as a 2-bit index into a 4-entry table that is read from a third field. In both forms, a 4-bit write mask decides which bits of the destination field take the new value. The other bits keep their old value.

An instruction is presented on `instr` with `issue_valid` for one cycle. Its effect is visible on `cr_out` at the next clock edge. An all-zero mask does not modify the register. It raises a one-cycle `illegal` pulse instead. A separate load port lets the surrounding pipeline set the whole register, and `cr_out` always shows the full register.

Top module: `crf_lut_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the register is cleared to 0 and `illegal` is driven to 0.
- R2: When `load_en` is high, `cr_out` equals `load_data` after the next edge. A load takes priority over an instruction issued in the same cycle. That instruction is dropped and raises no `illegal`.
- R3: Instruction bits are numbered big-endian, so bit k is `instr[31-k]`. Bits 0-5 must equal `PO_VAL` (default 5). Bits 26-30 select the form: `XO_TERN` (default 19) for ternary and `XO_BIN` (default 8) for binary. Any other word leaves the register and `illegal` unchanged. The destination field number is in bits 6-8, the first source field number in bits 11-13, and the second source field number in bits 16-18.
- R4: Field n is `cr_out[31-4n -: 4]`. Its first bit (position 0) is the most significant bit of that slice.
- R5: In the ternary form, bit position i of the new destination field is table entry j, where j = {dest bit i, first-source bit i, second-source bit i}, with the destination bit most significant.
- R6: In the binary form, j = {dest bit i, first-source bit i}. The new bit is the bit at position j of the field named by bits 16-18. Bits 19-25 and bit 31 are ignored in this form.
- R7: The mask is {bits 9-10, bits 14-15}, so bit 9 is the mask MSB. Mask bit i enables writing field position i. Positions with a 0 mask bit keep their old value.
- R8: The ternary table is {bits 19-25, bit 31}, so bit 31 is table entry 0 and entry j is table bit j counted from the LSB.
- R9: An accepted instruction with mask 0 raises `illegal` for exactly the cycle after issue and leaves the register unchanged.
- R10: All fields are read before the write, so a destination that is also a source uses the old values.
- R11: Fields other than the destination never change when an instruction executes.
- R12: Instructions can be issued on consecutive cycles. Each one sees the register as updated by the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Instruction on `instr` is issued this cycle |
| instr | input | 32 | Instruction word, big-endian bit numbering |
| load_en | input | 1 | Overwrite the whole register with `load_data` |
| load_data | input | 32 | Value for a register load |
| cr_out | output | 32 | Current condition register contents |
| illegal | output | 1 | One-cycle pulse for a zero-mask instruction |

## Verification
Every result of this block is exactly one register stage after its cause. The new register value, the load value and the `illegal` pulse all appear after the first rising edge following the cycle in which the stimulus was held. The bench drives inputs on a falling edge and removes them at the next falling edge. It then samples `cr_out` and `illegal` at that same falling edge, which is half a period after the edge that registered them. Back-to-back issues are checked one falling edge apart, so each check sees the value due in that cycle, and the `illegal` pulse is confirmed to have dropped one cycle later.

// File: rtl/crf_pkg.sv
package crf_pkg;

  localparam int CR_W    = 32;
  localparam int FLD_W   = 4;
  localparam int NUM_FLD = CR_W / FLD_W;
  localparam int SEL_W   = $clog2(NUM_FLD);
  localparam int TBL_W   = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TERN = 2'd1,
    OP_BIN  = 2'd2
  } op_e;

  typedef struct packed {
    op_e                op;
    logic [SEL_W-1:0]   dst;
    logic [SEL_W-1:0]   src_a;
    logic [SEL_W-1:0]   src_b;
    logic [FLD_W-1:0]   wmask;
    logic [TBL_W-1:0]   table_imm;
  } dec_t;

  // MSB bit index of field n inside the little-endian register vector
  function automatic int field_top(logic [SEL_W-1:0] n);
    return CR_W - 1 - FLD_W * int'(n);
  endfunction

  function automatic logic [FLD_W-1:0] field_get(logic [CR_W-1:0] cr,
                                                 logic [SEL_W-1:0] n);
    return cr[field_top(n) -: FLD_W];
  endfunction

  function automatic logic [CR_W-1:0] field_put(logic [CR_W-1:0] cr,
                                                logic [SEL_W-1:0] n,
                                                logic [FLD_W-1:0] v);
    logic [CR_W-1:0] r;
    r = cr;
    r[field_top(n) -: FLD_W] = v;
    return r;
  endfunction

  // Mask bit i addresses field position i; position 0 is the vector MSB
  function automatic logic [FLD_W-1:0] mask_to_vec(logic [FLD_W-1:0] m);
    logic [FLD_W-1:0] r;
    for (int k = 0; k < FLD_W; k++) r[FLD_W-1-k] = m[k];
    return r;
  endfunction

  function automatic logic tern_pick(logic [TBL_W-1:0] tbl,
                                     logic d, logic a, logic b);
    return tbl[{d, a, b}];
  endfunction

  // Table entry j lives at field position j, i.e. vector bit FLD_W-1-j
  function automatic logic bin_pick(logic [FLD_W-1:0] lut, logic d, logic a);
    logic [1:0] j;
    j = {d, a};
    return lut[2'd3 - j];
  endfunction

endpackage

// File: rtl/crf_decode.sv
module crf_decode
  import crf_pkg::*;
#(
  parameter logic [5:0] PO_VAL  = 6'd5,
  parameter logic [4:0] XO_TERN = 5'd19,
  parameter logic [4:0] XO_BIN  = 5'd8
) (
  input  logic [CR_W-1:0] instr,
  output dec_t            dec
);

  // Big-endian instruction bit k sits at instr[31-k]
  function automatic logic ibit(logic [CR_W-1:0] w, int k);
    return w[CR_W-1-k];
  endfunction

  logic [5:0] po_f;
  logic [4:0] xo_f;

  always_comb begin
    for (int k = 0; k < 6; k++) po_f[5-k] = ibit(instr, k);
    for (int k = 0; k < 5; k++) xo_f[4-k] = ibit(instr, 26 + k);

    dec = '0;
    for (int k = 0; k < SEL_W; k++) begin
      dec.dst[SEL_W-1-k]   = ibit(instr, 6 + k);
      dec.src_a[SEL_W-1-k] = ibit(instr, 11 + k);
      dec.src_b[SEL_W-1-k] = ibit(instr, 16 + k);
    end
    dec.wmask = {ibit(instr, 9), ibit(instr, 10), ibit(instr, 14), ibit(instr, 15)};
    for (int k = 0; k < 7; k++) dec.table_imm[TBL_W-1-k] = ibit(instr, 19 + k);
    dec.table_imm[0] = ibit(instr, 31);

    if (po_f != PO_VAL)        dec.op = OP_NONE;
    else if (xo_f == XO_TERN)  dec.op = OP_TERN;
    else if (xo_f == XO_BIN)   dec.op = OP_BIN;
    else                       dec.op = OP_NONE;
  end

endmodule

// File: rtl/crf_field_read.sv
module crf_field_read
  import crf_pkg::*;
(
  input  logic [CR_W-1:0]  cr,
  input  logic [SEL_W-1:0] sel,
  output logic [FLD_W-1:0] fld
);

  logic [FLD_W-1:0] slices [NUM_FLD];

  for (genvar n = 0; n < NUM_FLD; n++) begin : g_slice
    assign slices[n] = cr[CR_W-1-FLD_W*n -: FLD_W];
  end

  assign fld = slices[sel];

endmodule

// File: rtl/crf_eval.sv
module crf_eval
  import crf_pkg::*;
(
  input  op_e              op,
  input  logic [TBL_W-1:0] table_imm,
  input  logic [FLD_W-1:0] wmask,
  input  logic [FLD_W-1:0] f_dst,
  input  logic [FLD_W-1:0] f_a,
  input  logic [FLD_W-1:0] f_b,
  output logic [FLD_W-1:0] merged
);

  logic [FLD_W-1:0] wvec;
  assign wvec = mask_to_vec(wmask);

  for (genvar k = 0; k < FLD_W; k++) begin : g_bit
    logic res;
    always_comb begin
      if (op == OP_TERN) res = tern_pick(table_imm, f_dst[k], f_a[k], f_b[k]);
      else               res = bin_pick(f_b, f_dst[k], f_a[k]);
    end
    assign merged[k] = wvec[k] ? res : f_dst[k];
  end

endmodule

// File: rtl/crf_lut_unit.sv
module crf_lut_unit
  import crf_pkg::*;
#(
  parameter logic [5:0] PO_VAL  = 6'd5,
  parameter logic [4:0] XO_TERN = 5'd19,
  parameter logic [4:0] XO_BIN  = 5'd8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        issue_valid,
  input  logic [31:0] instr,
  input  logic        load_en,
  input  logic [31:0] load_data,
  output logic [31:0] cr_out,
  output logic        illegal
);

  logic [CR_W-1:0]  cr_q;
  logic             illegal_q;
  dec_t             dec;
  logic [FLD_W-1:0] f_dst, f_a, f_b, merged_w;
  logic             accept_w, commit_w, trap_w;
  logic [CR_W-1:0]  cr_exec_w;

  crf_decode #(.PO_VAL(PO_VAL), .XO_TERN(XO_TERN), .XO_BIN(XO_BIN)) u_dec (
    .instr (instr),
    .dec   (dec)
  );

  crf_field_read u_rd_dst (.cr(cr_q), .sel(dec.dst),   .fld(f_dst));
  crf_field_read u_rd_a   (.cr(cr_q), .sel(dec.src_a), .fld(f_a));
  crf_field_read u_rd_b   (.cr(cr_q), .sel(dec.src_b), .fld(f_b));

  crf_eval u_eval (
    .op        (dec.op),
    .table_imm (dec.table_imm),
    .wmask     (dec.wmask),
    .f_dst     (f_dst),
    .f_a       (f_a),
    .f_b       (f_b),
    .merged    (merged_w)
  );

  assign accept_w  = issue_valid && !load_en && (dec.op != OP_NONE);
  assign trap_w    = accept_w && (dec.wmask == '0);
  assign commit_w  = accept_w && (dec.wmask != '0);
  assign cr_exec_w = field_put(cr_q, dec.dst, merged_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      cr_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= trap_w;
      if (load_en)       cr_q <= load_data;
      else if (commit_w) cr_q <= cr_exec_w;
    end
  end

  assign cr_out  = cr_q;
  assign illegal = illegal_q;

endmodule

// File: rtl/crf_lut_unit_chk.sv
module crf_lut_unit_chk
  import crf_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic        load_en,
  input logic [31:0] load_data,
  input logic [31:0] cr_out,
  input logic        illegal,
  input logic        commit_w,
  input logic        trap_w
);

  logic [CR_W-1:0] allow_w;
  logic [2:0]      dst_sel;
  logic [3:0]      msk;

  assign dst_sel = instr[25:23];
  assign msk     = {instr[22:21], instr[17:16]};
  assign allow_w = field_put('0, dst_sel, mask_to_vec(msk));

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (cr_out == '0 && !illegal));

  p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
    $past(load_en) |-> (cr_out == $past(load_data) && !illegal));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(commit_w) && !$past(load_en)) |-> $stable(cr_out));

  p_write_confined_r7: assert property (@(posedge clk) disable iff (rst)
    $past(commit_w) |-> (((cr_out ^ $past(cr_out)) & ~$past(allow_w)) == '0));

  p_trap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (cr_out == $past(cr_out)));

  p_trap_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    $past(trap_w) |-> illegal);

  p_trap_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(commit_w && trap_w));

endmodule

bind crf_lut_unit crf_lut_unit_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr     (instr),
  .load_en   (load_en),
  .load_data (load_data),
  .cr_out    (cr_out),
  .illegal   (illegal),
  .commit_w  (commit_w),
  .trap_w    (trap_w)
);

// File: tb/crf_lut_unit_tb.sv
module crf_lut_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] PO  = 6'd5;
  localparam logic [4:0] XT  = 5'd19;
  localparam logic [4:0] XB  = 5'd8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0;
  logic        load_en = 1'b0;
  logic [31:0] load_data = '0;
  logic [31:0] cr_out;
  logic        illegal;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crf_lut_unit u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .instr(instr),
    .load_en(load_en), .load_data(load_data), .cr_out(cr_out), .illegal(illegal)
  );

  // Place a value msb-first into big-endian bits lo..lo+len-1
  function automatic logic [31:0] place(logic [31:0] w, int lo, int len, logic [31:0] v);
    for (int k = 0; k < len; k++) w[31-(lo+k)] = v[len-1-k];
    return w;
  endfunction

  function automatic logic [31:0] mk(logic [5:0] po, logic [4:0] xo, logic [2:0] bf,
                                     logic [2:0] ba, logic [2:0] bb, logic [3:0] m,
                                     logic [7:0] tbl);
    logic [31:0] w;
    w = place('0, 0, 6, 32'(po));
    w = place(w, 6, 3, 32'(bf));
    w = place(w, 9, 2, 32'(m[3:2]));
    w = place(w, 11, 3, 32'(ba));
    w = place(w, 14, 2, 32'(m[1:0]));
    w = place(w, 16, 3, 32'(bb));
    w = place(w, 19, 7, 32'(tbl[7:1]));
    w = place(w, 26, 5, 32'(xo));
    w = place(w, 31, 1, 32'(tbl[0]));
    return w;
  endfunction

  // Register bit 32+p (big-endian) is vector bit 31-p
  function automatic logic crb(logic [31:0] cr, int p);
    return cr[31-p];
  endfunction

  function automatic logic [31:0] ref_exec(logic [31:0] cr, bit tern, logic [2:0] bf,
                                           logic [2:0] ba, logic [2:0] bb,
                                           logic [3:0] m, logic [7:0] tbl);
    logic [31:0] nw;
    nw = cr;
    for (int i = 0; i < 4; i++) begin
      int j;
      logic a, b, c, r;
      a = crb(cr, 4*int'(bf) + i);
      b = crb(cr, 4*int'(ba) + i);
      c = crb(cr, 4*int'(bb) + i);
      if (tern) begin
        j = 4*int'(a) + 2*int'(b) + int'(c);
        r = tbl[j];
      end else begin
        j = 2*int'(a) + int'(b);
        r = crb(cr, 4*int'(bb) + j);
      end
      if (m[i]) nw[31-(4*int'(bf)+i)] = r;
    end
    return nw;
  endfunction

  task automatic check(string req, logic [31:0] exp_cr, logic exp_ill);
    vectors++;
    if (cr_out !== exp_cr || illegal !== exp_ill) begin
      errors++;
      $display("FAIL %s: cr_out=%h illegal=%b expected cr_out=%h illegal=%b",
               req, cr_out, illegal, exp_cr, exp_ill);
    end
  endtask

  task automatic do_load(logic [31:0] v);
    @(negedge clk);
    load_en = 1'b1; load_data = v;
    @(negedge clk);
    load_en = 1'b0;
    model = v;
  endtask

  task automatic do_issue(logic [31:0] w);
    @(negedge clk);
    issue_valid = 1'b1; instr = w;
    @(negedge clk);
    issue_valid = 1'b0; instr = '0;
  endtask

  task automatic run_op(string req, bit tern, logic [2:0] bf, logic [2:0] ba,
                        logic [2:0] bb, logic [3:0] m, logic [7:0] tbl);
    do_issue(mk(PO, tern ? XT : XB, bf, ba, bb, m, tbl));
    model = ref_exec(model, tern, bf, ba, bb, m, tbl);
    check(req, model, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", 32'h0, 1'b0);
  endtask

  task automatic t_load();
    do_load(32'hA5C3_0F96);
    check("R2", 32'hA5C3_0F96, 1'b0);
    // R2: load and issue in the same cycle, load wins
    @(negedge clk);
    load_en = 1'b1; load_data = 32'h1234_5678;
    issue_valid = 1'b1; instr = mk(PO, XT, 3'd0, 3'd1, 3'd2, 4'h0, 8'hFF);
    @(negedge clk);
    load_en = 1'b0; issue_valid = 1'b0; instr = '0;
    model = 32'h1234_5678;
    check("R2", model, 1'b0);
  endtask

  task automatic t_ternary();
    do_load(32'h6C3A_F05E);
    run_op("R5", 1, 3'd2, 3'd5, 3'd7, 4'hF, 8'hE8);
    run_op("R5", 1, 3'd0, 3'd3, 3'd6, 4'hF, 8'h96);
    run_op("R11", 1, 3'd7, 3'd1, 3'd4, 4'hF, 8'h5B);
    // R4: field 0 is the top nibble; copy-of-source-a table
    do_load(32'h0000_000B);
    run_op("R4", 1, 3'd0, 3'd7, 3'd7, 4'hF, 8'hCC);
    check("R4", 32'hB000_000B, 1'b0);
  endtask

  task automatic t_table_split();
    // R8: only entry 0 set, lives in bit 31; all-zero operands pick it
    do_load(32'h0);
    run_op("R8", 1, 3'd3, 3'd4, 3'd5, 4'hF, 8'h01);
    check("R8", 32'h000F_0000, 1'b0);
    run_op("R8", 1, 3'd1, 3'd4, 3'd5, 4'hF, 8'h80);
  endtask

  task automatic t_binary();
    do_load(32'h9E21_7D4C);
    run_op("R6", 0, 3'd1, 3'd2, 3'd3, 4'hF, 8'h00);
    run_op("R6", 0, 3'd4, 3'd0, 3'd6, 4'hF, 8'hFF);
    // R6: lut field 0x8 means only entry 0 (first bit) is one
    do_load(32'h8000_0000);
    run_op("R6", 0, 3'd2, 3'd3, 3'd0, 4'hF, 8'h00);
    check("R6", 32'h80F0_0000, 1'b0);
  endtask

  task automatic t_mask();
    do_load(32'h0);
    // R7: mask 0b0001 writes field position 0, the nibble MSB
    run_op("R7", 1, 3'd5, 3'd0, 3'd0, 4'h1, 8'hFF);
    check("R7", 32'h0000_0800, 1'b0);
    run_op("R7", 1, 3'd5, 3'd0, 3'd0, 4'hA, 8'hFF);
    run_op("R7", 0, 3'd6, 3'd1, 3'd5, 4'h6, 8'h00);
  endtask

  task automatic t_trap();
    do_load(32'hDEAD_BEEF);
    do_issue(mk(PO, XT, 3'd2, 3'd3, 3'd4, 4'h0, 8'hFF));
    check("R9", model, 1'b1);
    @(negedge clk);
    check("R9", model, 1'b0);
    do_issue(mk(PO, XB, 3'd6, 3'd3, 3'd4, 4'h0, 8'h00));
    check("R9", model, 1'b1);
  endtask

  task automatic t_alias();
    do_load(32'h3C5A_96E1);
    run_op("R10", 1, 3'd3, 3'd3, 3'd3, 4'hF, 8'h0F);
    run_op("R10", 0, 3'd5, 3'd5, 3'd5, 4'hF, 8'h00);
    run_op("R10", 1, 3'd1, 3'd6, 3'd1, 4'hF, 8'h6A);
  endtask

  task automatic t_decode();
    do_load(32'h7777_7777);
    do_issue(mk(PO, 5'd7, 3'd0, 3'd1, 3'd2, 4'h0, 8'hFF));
    check("R3", model, 1'b0);
    do_issue(mk(6'd9, XT, 3'd0, 3'd1, 3'd2, 4'hF, 8'h00));
    check("R3", model, 1'b0);
  endtask

  task automatic t_back_to_back();
    logic [31:0] w1, w2, e1;
    do_load(32'h5A5A_C3C3);
    w1 = mk(PO, XT, 3'd0, 3'd6, 3'd7, 4'hF, 8'h96);
    w2 = mk(PO, XB, 3'd1, 3'd0, 3'd0, 4'hF, 8'h00);
    @(negedge clk);
    issue_valid = 1'b1; instr = w1;
    @(negedge clk);
    instr = w2;
    e1 = ref_exec(model, 1, 3'd0, 3'd6, 3'd7, 4'hF, 8'h96);
    check("R12", e1, 1'b0);
    @(negedge clk);
    issue_valid = 1'b0; instr = '0;
    model = ref_exec(e1, 0, 3'd1, 3'd0, 3'd0, 4'hF, 8'h00);
    check("R12", model, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_ternary();
    t_table_split();
    t_binary();
    t_mask();
    t_trap();
    t_alias();
    t_decode();
    t_back_to_back();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule